// File: doc/BRIEF.md
# Single-Tone Phase Synthesis Core

This block is the numeric heart of a direct digital synthesizer in its
single-tone mode. A wide phase accumulator advances by a frequency tuning word
on every system clock, so the output frequency is FTW × f_clk / 2^ACC_W. That
gives a range from DC up to half the clock rate. The top PHASE_W bits of the
accumulator are shifted by a programmable phase offset. The result is
registered and handed, together with an amplitude word, to a sine/cosine lookup
stage that sits downstream.

Software programs the parameters through a narrow register write port into
shadow copies. A separate update strobe moves every shadow value into the
active set on one clock edge. A change of frequency therefore never clears the
accumulator, and the waveform stays phase-continuous.

A three-bit operating-mode field is stored as well. Code 000 is single-tone.
Codes 001 (two-tone keying), 010 (ramped keying), 011 (linear sweep) and
100 (binary phase keying) are decoded but not built. Codes 101 to 111 are
invalid. Once any of these non-zero codes becomes active, a sticky flag is
raised, and the core keeps running in single-tone behaviour.

Top module: `dds_tone_core`

## Requirements
- R1: While reset is high and on the first cycle after it, the outputs are as follows. phase_out is 0. amp_out is the midscale code: 0x800 in offset-binary format (default) and 0 in signed-magnitude format. mode_bad is 0. The tuning word is 0, so phase_out stays 0 until an update is made.
- R2: On every clock the accumulator adds the active tuning word, modulo 2^ACC_W. phase_out after an edge equals the top PHASE_W bits of the accumulator before that edge plus the active phase offset, which is one cycle of latency.
- R3: Register writes only change shadow registers, and the outputs do not move until upd is pulsed. The write map is as follows. Address 0 holds FTW[15:0], address 1 holds FTW[31:16] and address 2 holds FTW[47:32]. Address 3 holds the phase offset in data[13:0], address 4 the amplitude in data[11:0], and address 5 the mode in data[2:0].
- R4: A cycle with upd high copies all shadow registers to the active set on the same edge, using the shadow contents held before that edge.
- R5: A tuning-word change is phase-continuous: the accumulator is never cleared, and the new increment continues from the last accumulated phase.
- R6: The phase offset is added to the accumulator's top bits modulo 2^PHASE_W.
- R7: amp_out holds midscale until an update commits an amplitude that was written after reset. From the cycle after that update, amp_out equals the committed amplitude word.
- R8: When an active mode code other than 000 is present, mode_bad is set one cycle after the update that makes it active. Phase and amplitude keep single-tone behaviour.
- R9: Writes to unmapped addresses 6 and 7 are ignored.
- R10: mode_bad stays set, even after mode 000 is committed again, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| upd | input | 1 | Update strobe: commit shadow to active |
| phase_out | output | 14 | Offset phase word for the lookup stage |
| amp_out | output | 12 | Amplitude word for the lookup stage |
| mode_bad | output | 1 | Sticky unsupported-mode flag |

## Verification
The bound assertions watch the following on every cycle:
- the reset state;
- that the active tuning word holds between updates;
- that an update edge still advances the accumulator from its old value;
- that amplitude stays at midscale until an amplitude has gone live;
- that the mode flag never clears.

The exact phase sequence needs the bench's scenarios and its cycle-accurate reference model. These cover 48-bit wraparound, offset wraparound modulo 2^14, shadow writes left pending, unmapped addresses, and the pairing of a keying or invalid mode with continued single-tone output.

// File: rtl/dds_tone_pkg.sv
package dds_tone_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_TONE  = 3'b000,
    MODE_FSK   = 3'b001,
    MODE_RFSK  = 3'b010,
    MODE_SWEEP = 3'b011,
    MODE_BPSK  = 3'b100
  } dds_mode_e;

  // Only single-tone is built; keying, sweep and codes 101..111 are flagged.
  function automatic logic mode_unsupported(input logic [MODE_W-1:0] code);
    return code != MODE_TONE;
  endfunction

endpackage

// File: rtl/dds_tone_regs.sv
module dds_tone_regs
  import dds_tone_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3,
  parameter int ACC_W   = 48,
  parameter int PHASE_W = 14,
  parameter int AMP_W   = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                upd,
  output logic [ACC_W-1:0]    ftw_act,
  output logic [PHASE_W-1:0]  poff_act,
  output logic [AMP_W-1:0]    amp_act,
  output logic                amp_live,
  output logic [MODE_W-1:0]   mode_act
);

  localparam int FTW_WORDS = (ACC_W + DATA_W - 1) / DATA_W;
  localparam int A_POFF    = FTW_WORDS;
  localparam int A_AMP     = FTW_WORDS + 1;
  localparam int A_MODE    = FTW_WORDS + 2;

  logic [FTW_WORDS*DATA_W-1:0] ftw_cat;
  logic [PHASE_W-1:0]          poff_sh;
  logic [AMP_W-1:0]            amp_sh;
  logic                        amp_wr_sh;
  logic [MODE_W-1:0]           mode_sh;

  // One shadow word per slice of the tuning word.
  for (genvar i = 0; i < FTW_WORDS; i++) begin : g_ftw
    logic [DATA_W-1:0] word;
    always_ff @(posedge clk) begin
      if (rst)
        word <= '0;
      else if (wr_en && wr_addr == ADDR_W'(i))
        word <= wr_data;
    end
    assign ftw_cat[i*DATA_W +: DATA_W] = word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      poff_sh   <= '0;
      amp_sh    <= '0;
      amp_wr_sh <= 1'b0;
      mode_sh   <= MODE_TONE;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(A_POFF)) poff_sh <= wr_data[PHASE_W-1:0];
      if (wr_addr == ADDR_W'(A_AMP)) begin
        amp_sh    <= wr_data[AMP_W-1:0];
        amp_wr_sh <= 1'b1;
      end
      if (wr_addr == ADDR_W'(A_MODE)) mode_sh <= wr_data[MODE_W-1:0];
    end
  end

  // Commit: every active field changes on the same edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      ftw_act  <= '0;
      poff_act <= '0;
      amp_act  <= '0;
      amp_live <= 1'b0;
      mode_act <= MODE_TONE;
    end else if (upd) begin
      ftw_act  <= ftw_cat[ACC_W-1:0];
      poff_act <= poff_sh;
      amp_act  <= amp_sh;
      amp_live <= amp_live | amp_wr_sh;
      mode_act <= mode_sh;
    end
  end

endmodule

// File: rtl/dds_tone_acc.sv
module dds_tone_acc #(
  parameter int ACC_W   = 48,
  parameter int PHASE_W = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ACC_W-1:0]   ftw,
  input  logic [PHASE_W-1:0] poff,
  output logic [ACC_W-1:0]   acc_q,
  output logic [PHASE_W-1:0] phase_q
);

  localparam int TOP = ACC_W - 1;

  // The accumulator is only ever cleared by reset, never by a commit.
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      phase_q <= '0;
    end else begin
      acc_q   <= acc_q + ftw;
      phase_q <= acc_q[TOP -: PHASE_W] + poff;
    end
  end

endmodule

// File: rtl/dds_tone_mode.sv
module dds_tone_mode
  import dds_tone_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  output logic              bad_q
);

  always_ff @(posedge clk) begin
    if (rst)
      bad_q <= 1'b0;
    else
      bad_q <= bad_q | mode_unsupported(mode);
  end

endmodule

// File: rtl/dds_tone_amp.sv
module dds_tone_amp #(
  parameter int AMP_W         = 12,
  parameter bit OFFSET_BINARY = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             live,
  input  logic [AMP_W-1:0] amp,
  output logic [AMP_W-1:0] amp_q
);

  localparam logic [AMP_W-1:0] MID =
    OFFSET_BINARY ? (AMP_W)'(1) << (AMP_W - 1) : '0;

  always_ff @(posedge clk) begin
    if (rst)
      amp_q <= MID;
    else
      amp_q <= live ? amp : MID;
  end

endmodule

// File: rtl/dds_tone_core.sv
module dds_tone_core
  import dds_tone_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int ADDR_W        = 3,
  parameter int ACC_W         = 48,
  parameter int PHASE_W       = 14,
  parameter int AMP_W         = 12,
  parameter bit OFFSET_BINARY = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               upd,
  output logic [PHASE_W-1:0] phase_out,
  output logic [AMP_W-1:0]   amp_out,
  output logic               mode_bad
);

  logic [ACC_W-1:0]   ftw_act;
  logic [PHASE_W-1:0] poff_act;
  logic [AMP_W-1:0]   amp_act;
  logic               amp_live;
  logic [MODE_W-1:0]  mode_act;
  logic [ACC_W-1:0]   acc_q;

  dds_tone_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ACC_W(ACC_W),
    .PHASE_W(PHASE_W), .AMP_W(AMP_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .upd(upd), .ftw_act(ftw_act),
    .poff_act(poff_act), .amp_act(amp_act), .amp_live(amp_live),
    .mode_act(mode_act)
  );

  dds_tone_acc #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) u_acc (
    .clk(clk), .rst(rst), .ftw(ftw_act), .poff(poff_act),
    .acc_q(acc_q), .phase_q(phase_out)
  );

  dds_tone_mode u_mode (
    .clk(clk), .rst(rst), .mode(mode_act), .bad_q(mode_bad)
  );

  dds_tone_amp #(.AMP_W(AMP_W), .OFFSET_BINARY(OFFSET_BINARY)) u_amp (
    .clk(clk), .rst(rst), .live(amp_live), .amp(amp_act), .amp_q(amp_out)
  );

endmodule

// File: rtl/dds_tone_core_chk.sv
module dds_tone_core_chk #(
  parameter int ACC_W         = 48,
  parameter int PHASE_W       = 14,
  parameter int AMP_W         = 12,
  parameter bit OFFSET_BINARY = 1'b1
) (
  input logic               clk,
  input logic               rst,
  input logic               upd,
  input logic [ACC_W-1:0]   acc,
  input logic [ACC_W-1:0]   ftw_act,
  input logic               amp_live,
  input logic [PHASE_W-1:0] phase_out,
  input logic [AMP_W-1:0]   amp_out,
  input logic               mode_bad
);

  localparam logic [AMP_W-1:0] MID =
    OFFSET_BINARY ? (AMP_W)'(1) << (AMP_W - 1) : '0;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (phase_out == '0 && amp_out == MID && !mode_bad)); // R1

  AST_ZERO_STEP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (ftw_act == '0) |=> $stable(acc)); // R2

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(ftw_act)); // R3

  AST_NO_CLEAR_ON_UPD: assert property (@(posedge clk) disable iff (rst)
    upd |=> acc == $past(acc) + $past(ftw_act)); // R5

  AST_MID_UNTIL_LIVE: assert property (@(posedge clk) disable iff (rst)
    !$past(amp_live) |-> amp_out == MID); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    mode_bad |=> mode_bad); // R10

endmodule

bind dds_tone_core dds_tone_core_chk #(
  .ACC_W(ACC_W), .PHASE_W(PHASE_W), .AMP_W(AMP_W),
  .OFFSET_BINARY(OFFSET_BINARY)
) u_chk (
  .clk(clk), .rst(rst), .upd(upd), .acc(acc_q), .ftw_act(ftw_act),
  .amp_live(amp_live), .phase_out(phase_out), .amp_out(amp_out),
  .mode_bad(mode_bad)
);

// File: tb/sim_dds_tone_core.sv
module sim_dds_tone_core;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;
  localparam int ACC_W  = 48;
  localparam int PH_W   = 14;
  localparam int AMP_W  = 12;
  localparam logic [AMP_W-1:0] MID = 12'h800;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              upd = 1'b0;
  logic [PH_W-1:0]   phase_out;
  logic [AMP_W-1:0]  amp_out;
  logic              mode_bad;

  always #5 clk = ~clk;

  dds_tone_core u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .upd(upd), .phase_out(phase_out),
    .amp_out(amp_out), .mode_bad(mode_bad)
  );

  typedef struct packed {
    logic [PH_W-1:0]  ph;
    logic [AMP_W-1:0] amp;
    logic             bad;
  } exp_t;

  exp_t q[$];
  exp_t last;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;

  // Reference model built from the requirements
  logic [ACC_W-1:0] m_acc, m_ftw, m_ftw_sh;
  logic [PH_W-1:0]  m_poff, m_poff_sh;
  logic [AMP_W-1:0] m_amp, m_amp_sh;
  logic             m_amp_wr, m_live, m_bad;
  logic [2:0]       m_mode, m_mode_sh;

  always @(posedge clk) begin
    exp_t e;
    if (rst) begin
      e = '{ph: '0, amp: MID, bad: 1'b0};
      m_acc = '0; m_ftw = '0; m_ftw_sh = '0; m_poff = '0; m_poff_sh = '0;
      m_amp = '0; m_amp_sh = '0; m_amp_wr = 0; m_live = 0; m_bad = 0;
      m_mode = '0; m_mode_sh = '0;
    end else begin
      e.ph  = m_acc[ACC_W-1 -: PH_W] + m_poff;
      e.amp = m_live ? m_amp : MID;
      e.bad = m_bad | (m_mode != 3'b000);
      m_bad = e.bad;
      m_acc = m_acc + m_ftw;
      if (upd) begin
        m_ftw = m_ftw_sh; m_poff = m_poff_sh; m_amp = m_amp_sh;
        m_live = m_live | m_amp_wr; m_mode = m_mode_sh;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_ftw_sh[15:0]  = wr_data;
          3'd1: m_ftw_sh[31:16] = wr_data;
          3'd2: m_ftw_sh[47:32] = wr_data;
          3'd3: m_poff_sh = wr_data[PH_W-1:0];
          3'd4: begin m_amp_sh = wr_data[AMP_W-1:0]; m_amp_wr = 1; end
          3'd5: m_mode_sh = wr_data[2:0];
          default: ;
        endcase
      end
    end
    q.push_back(e);
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: pops expectations and compares every cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      last = q.pop_front();
      chk("R2 phase", 64'(phase_out), 64'(last.ph));
      chk("R7 amp", 64'(amp_out), 64'(last.amp));
      chk("R8 flag", 64'(mode_bad), 64'(last.bad));
    end
  end

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic commit();
    @(negedge clk);
    upd = 1;
    @(negedge clk);
    upd = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    settle(3);
    chk("R1 phase", 64'(phase_out), 64'h0);
    chk("R1 amp", 64'(amp_out), 64'(MID));
    chk("R1 flag", 64'(mode_bad), 64'h0);
    rst = 0;
    settle(5);
    chk("R1 zero ftw", 64'(phase_out), 64'h0);

    // R3: pending shadow write must not move the output
    wr(3'd2, 16'h0004);
    settle(4);
    chk("R3 pending", 64'(phase_out), 64'h0);

    // R4: commit, phase now steps by one per cycle
    commit();
    settle(6);
    chk("R4 commit", 64'(phase_out), 64'(last.ph));
    chk("R4 moving", 64'(phase_out != 0), 64'h1);

    // R5: continuous frequency change
    wr(3'd2, 16'h0100);
    wr(3'd0, 16'h1234);
    commit();
    #1;
    chk("R5 continuous", 64'(phase_out), 64'(last.ph));
    settle(3);
    chk("R5 after", 64'(phase_out), 64'(last.ph));

    // R6, R7: offset near wrap and amplitude
    wr(3'd3, 16'h3FF0);
    wr(3'd4, 16'h05A5);
    settle(2);
    chk("R7 pending mid", 64'(amp_out), 64'(MID));
    commit();
    settle(2);
    chk("R6 offset", 64'(phase_out), 64'(last.ph));
    chk("R7 amp live", 64'(amp_out), 64'h5A5);

    // R2: accumulator wraparound with a near-full tuning word
    wr(3'd0, 16'hFFFF);
    wr(3'd1, 16'hFFFF);
    wr(3'd2, 16'hFFFF);
    commit();
    settle(10);
    chk("R2 wrap", 64'(phase_out), 64'(last.ph));

    // R9: unmapped addresses
    wr(3'd6, 16'hFFFF);
    wr(3'd7, 16'h0ABC);
    commit();
    settle(3);
    chk("R9 amp", 64'(amp_out), 64'h5A5);
    chk("R9 flag", 64'(mode_bad), 64'h0);
    chk("R9 phase", 64'(phase_out), 64'(last.ph));

    // R8: invalid code 101
    wr(3'd5, 16'h0005);
    commit();
    settle(2);
    chk("R8 flag set", 64'(mode_bad), 64'h1);
    chk("R8 tone kept", 64'(phase_out), 64'(last.ph));

    // R10: back to 000, flag remains
    wr(3'd5, 16'h0000);
    commit();
    settle(4);
    chk("R10 sticky", 64'(mode_bad), 64'h1);

    // Reset again, then a keying code 001
    @(negedge clk); rst = 1;
    settle(2);
    rst = 0;
    chk("R1 re-reset amp", 64'(amp_out), 64'(MID));
    chk("R1 re-reset flag", 64'(mode_bad), 64'h0);
    wr(3'd5, 16'h0001);
    settle(2);
    chk("R8 not before commit", 64'(mode_bad), 64'h0);
    commit();
    settle(2);
    chk("R8 keying code", 64'(mode_bad), 64'h1);
    chk("R7 mid after reset", 64'(amp_out), 64'(MID));

    settle(2);
    done = 1;
    summary();
    $finish;
  end

endmodule